// File: doc/BRIEF.md
# Memory Parity Error Response Controller

This block decides what the processor does when main memory reports a parity error. It keeps a small software-visible control word with two action enables, one for trapping and one for halting, and a sticky record of whether an error has been seen. The memory side sends a one-cycle `parityErr` pulse whenever it detects bad parity on a read.

Depending on the enables, the block does one of three things. It can post a trap request carrying a fixed vector, which is held until the trap sequencer acknowledges it. It can fire a halt request and latch a console indication. It can also just record the error. A system init pulse, raised on processor start or by the init instruction, turns off the trap enable. It does not erase the error record or the halt enable.

Software writes and reads the control word over a single-cycle bus. Reads are combinational, and a write takes effect at the clock edge.

Top module: `parity_trap_ctl`

## Requirements
- R1: After reset `busRdData`, `trapReq`, `haltReq` and `consoleFlag` are all zero.
- R2: A write loads trap enable from `busWrData` bit 1 and halt enable from bit 2. `busRdData` shows the error flag at bit 0, trap enable at bit 1 and halt enable at bit 2, and every other bit reads as zero.
- R3: A `parityErr` pulse sets the error flag (bit 0), visible after the edge that samples the pulse.
- R4: The error flag is cleared only by a write with bit 0 set. A write with bit 0 at zero leaves it set, and so does `sysInit`. If an error arrives in the same cycle as the clearing write, the flag stays set.
- R5: `sysInit` clears trap enable and takes priority over a write in the same cycle. Halt enable is not changed by `sysInit`.
- R6: An error seen while trap enable is set and halt enable is clear raises `trapReq` after the edge. `trapVector` always carries 114 octal (76 decimal).
- R7: `trapReq` stays high until the edge that samples `trapAck` or `sysInit`. A new trap-mode error in that same cycle keeps it high.
- R8: An error seen while halt enable is set gives a `haltReq` pulse exactly one cycle long and sets `consoleFlag`. No trap is requested, even when trap enable is also set.
- R9: `consoleFlag` stays high until the edge that samples `sysInit`, unless a halt-mode error arrives in that same cycle.
- R10: An error seen with both enables clear only sets the error flag.
- R11: The action taken for an error depends on the enables held before that edge. A write in the same cycle affects only later errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| parityErr | input | 1 | One-cycle parity error pulse from memory |
| sysInit | input | 1 | Processor start / init pulse |
| busWrEn | input | 1 | Write strobe for the control word |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Current control word |
| trapAck | input | 1 | Trap sequencer has taken the trap |
| trapReq | output | 1 | Pending trap request |
| trapVector | output | VEC_W | Trap vector address |
| haltReq | output | 1 | One-cycle halt request |
| consoleFlag | output | 1 | Console indication of a parity halt |

## Verification
The bench builds the block with its default parameters: a 16-bit bus and a 9-bit vector set to 114 octal. The wide bus lets random writes put ones in the unused upper bits, so each read checks that those bits stay zero. The vector check compares against the decimal value 76. Random cycles raise error, init, write and acknowledge together at fairly high rates. This produces the collisions that matter here: a clearing write meeting a new error, init meeting a write, an acknowledge meeting a fresh trap, and an enable change in the cycle of an error.

// File: rtl/parity_trap_ctl_pkg.sv
package parity_trap_ctl_pkg;
  localparam int ERR_POS = 0;
  localparam int TE_POS  = 1;
  localparam int HE_POS  = 2;
  localparam int CTL_BITS = 3;

  typedef struct packed {
    logic errSet;
    logic errClr;
    logic teLoad;
    logic teVal;
    logic heLoad;
    logic heVal;
    logic trapSet;
    logic trapClr;
    logic haltFire;
    logic consSet;
    logic consClr;
  } parStrobe_t;
endpackage

// File: rtl/parity_trap_ctl_seq.sv
module parity_trap_ctl_seq
  import parity_trap_ctl_pkg::*;
(
  input  logic                parityErr,
  input  logic                sysInit,
  input  logic                busWrEn,
  input  logic [CTL_BITS-1:0] wrBits,
  input  logic                trapAck,
  input  logic                trapEn,
  input  logic                haltEn,
  output parStrobe_t          stb
);
  logic haltHit;
  logic trapHit;

  // halt outranks trap; enables used are the ones held before this edge
  assign haltHit = parityErr & haltEn;
  assign trapHit = parityErr & trapEn & ~haltEn;

  always_comb begin
    stb          = '0;
    stb.errSet   = parityErr;
    stb.errClr   = busWrEn & wrBits[ERR_POS] & ~parityErr;
    stb.teLoad   = busWrEn | sysInit;
    stb.teVal    = ~sysInit & wrBits[TE_POS];
    stb.heLoad   = busWrEn;
    stb.heVal    = wrBits[HE_POS];
    stb.trapSet  = trapHit;
    stb.trapClr  = (trapAck | sysInit) & ~trapHit;
    stb.haltFire = haltHit;
    stb.consSet  = haltHit;
    stb.consClr  = sysInit & ~haltHit;
  end
endmodule

// File: rtl/parity_trap_ctl_regs.sv
module parity_trap_ctl_regs
  import parity_trap_ctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  parStrobe_t        stb,
  output logic              trapEn,
  output logic              haltEn,
  output logic              trapReq,
  output logic              haltReq,
  output logic              consoleFlag,
  output logic [DATA_W-1:0] rdWord
);
  logic errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag     <= 1'b0;
      trapEn      <= 1'b0;
      haltEn      <= 1'b0;
      trapReq     <= 1'b0;
      haltReq     <= 1'b0;
      consoleFlag <= 1'b0;
    end else begin
      if (stb.errSet)      errFlag <= 1'b1;
      else if (stb.errClr) errFlag <= 1'b0;
      if (stb.teLoad)      trapEn  <= stb.teVal;
      if (stb.heLoad)      haltEn  <= stb.heVal;
      if (stb.trapSet)      trapReq <= 1'b1;
      else if (stb.trapClr) trapReq <= 1'b0;
      haltReq <= stb.haltFire;
      if (stb.consSet)      consoleFlag <= 1'b1;
      else if (stb.consClr) consoleFlag <= 1'b0;
    end
  end

  always_comb begin
    rdWord         = '0;
    rdWord[ERR_POS] = errFlag;
    rdWord[TE_POS]  = trapEn;
    rdWord[HE_POS]  = haltEn;
  end
endmodule

// File: rtl/parity_trap_ctl.sv
module parity_trap_ctl
  import parity_trap_ctl_pkg::*;
#(
  parameter int             DATA_W   = 16,
  parameter int             VEC_W    = 9,
  parameter logic [VEC_W-1:0] TRAP_VEC = 9'o114
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityErr,
  input  logic              sysInit,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              trapAck,
  output logic              trapReq,
  output logic [VEC_W-1:0]  trapVector,
  output logic              haltReq,
  output logic              consoleFlag
);
  parStrobe_t stb;
  logic       trapEn;
  logic       haltEn;

  parity_trap_ctl_seq u_seq (
    .parityErr (parityErr),
    .sysInit   (sysInit),
    .busWrEn   (busWrEn),
    .wrBits    (busWrData[CTL_BITS-1:0]),
    .trapAck   (trapAck),
    .trapEn    (trapEn),
    .haltEn    (haltEn),
    .stb       (stb)
  );

  parity_trap_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .trapEn      (trapEn),
    .haltEn      (haltEn),
    .trapReq     (trapReq),
    .haltReq     (haltReq),
    .consoleFlag (consoleFlag),
    .rdWord      (busRdData)
  );

  assign trapVector = TRAP_VEC;
endmodule

// File: rtl/parity_trap_ctl_chk.sv
module parity_trap_ctl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              parityErr,
  input logic              sysInit,
  input logic              busWrEn,
  input logic              trapAck,
  input logic [DATA_W-1:0] busRdData,
  input logic              trapReq,
  input logic              haltReq,
  input logic              consoleFlag
);
  // R3
  err_sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> busRdData[0]);

  // R5
  init_clears_te_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysInit |=> !busRdData[1]);

  // R6
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trapReq) |-> $past(parityErr && busRdData[1] && !busRdData[2]));

  // R7
  trap_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapAck && !parityErr) |=> !trapReq);

  // R8
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> ($past(parityErr && busRdData[2]) && consoleFlag));

  // R8
  halt_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> !$rose(trapReq));

  // R9
  console_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (consoleFlag && !sysInit) |=> consoleFlag);

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[0] && !busWrEn) |=> busRdData[0]);
endmodule

bind parity_trap_ctl parity_trap_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .parityErr   (parityErr),
  .sysInit     (sysInit),
  .busWrEn     (busWrEn),
  .trapAck     (trapAck),
  .busRdData   (busRdData),
  .trapReq     (trapReq),
  .haltReq     (haltReq),
  .consoleFlag (consoleFlag)
);

// File: tb/test_parity_trap_ctl.sv
module test_parity_trap_ctl;
  localparam int DW = 16;
  localparam int VW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          parityErr = 1'b0;
  logic          sysInit = 1'b0;
  logic          busWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic          trapAck = 1'b0;
  logic          trapReq;
  logic [VW-1:0] trapVector;
  logic          haltReq;
  logic          consoleFlag;

  int checks = 0;
  int errors = 0;
  logic mErr, mTe, mHe, mTrap, mHalt, mCons;

  always #2 clk = ~clk;

  parity_trap_ctl i_parity_trap_ctl (
    .clk(clk), .rstN(rstN), .parityErr(parityErr), .sysInit(sysInit),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .trapAck(trapAck), .trapReq(trapReq), .trapVector(trapVector),
    .haltReq(haltReq), .consoleFlag(consoleFlag)
  );

  function automatic logic [DW-1:0] expWord(logic e, logic t, logic h);
    logic [DW-1:0] w = '0;
    w[0] = e; w[1] = t; w[2] = h;
    return w;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(logic pe, logic ini, logic wr, logic [DW-1:0] d, logic ack);
    logic hh, th;
    hh = pe & mHe;
    th = pe & mTe & ~mHe;
    mErr  = pe ? 1'b1 : (wr & d[0]) ? 1'b0 : mErr;
    mTe   = ini ? 1'b0 : wr ? d[1] : mTe;
    mHe   = wr ? d[2] : mHe;
    mTrap = th ? 1'b1 : (ack | ini) ? 1'b0 : mTrap;
    mHalt = hh;
    mCons = hh ? 1'b1 : ini ? 1'b0 : mCons;
  endtask

  task automatic checkAll();
    chk("R2/R3/R4 rdData", busRdData, expWord(mErr, mTe, mHe));
    chk("R6/R7 trapReq", {15'd0, trapReq}, {15'd0, mTrap});
    chk("R8 haltReq", {15'd0, haltReq}, {15'd0, mHalt});
    chk("R9 consoleFlag", {15'd0, consoleFlag}, {15'd0, mCons});
  endtask

  task automatic cyc(logic pe, logic ini, logic wr, logic [DW-1:0] d, logic ack);
    parityErr = pe; sysInit = ini; busWrEn = wr; busWrData = d; trapAck = ack;
    @(posedge clk);
    modelStep(pe, ini, wr, d, ack);
    @(negedge clk);
    parityErr = 0; sysInit = 0; busWrEn = 0; trapAck = 0;
    checkAll();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mErr = 0; mTe = 0; mHe = 0; mTrap = 0; mHalt = 0; mCons = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdData", busRdData, '0);
    chk("R1 outputs", {13'd0, trapReq, haltReq, consoleFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 vector 114 octal", {7'd0, trapVector}, 16'd76);
    // R2 write with upper bits set reads back only bits 1..2
    cyc(0, 0, 1, 16'hFFFE, 0);
    chk("R2 readback", busRdData, 16'h0006);
    // R10 no enables: only flag
    cyc(0, 0, 1, 16'h0000, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R10 flag only", {13'd0, busRdData[0], trapReq, haltReq}, 16'h0004);
    // R4 writing 0 keeps flag, init keeps flag, write 1 clears
    cyc(0, 0, 1, 16'h0000, 0);
    chk("R4 write0 keeps", {15'd0, busRdData[0]}, 16'd1);
    cyc(0, 1, 0, 0, 0);
    chk("R4 init keeps", {15'd0, busRdData[0]}, 16'd1);
    cyc(1, 0, 1, 16'h0001, 0);
    chk("R4 error beats clear", {15'd0, busRdData[0]}, 16'd1);
    cyc(0, 0, 1, 16'h0001, 0);
    chk("R4 w1c", {15'd0, busRdData[0]}, 16'd0);
    // R5 init beats write; halt enable kept
    cyc(0, 1, 1, 16'h0006, 0);
    chk("R5 te cleared", busRdData, 16'h0004);
    cyc(0, 1, 0, 0, 0);
    chk("R5 he kept", busRdData, 16'h0004);
    // R6/R7 trap mode
    cyc(0, 0, 1, 16'h0002, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R6 trap raised", {15'd0, trapReq}, 16'd1);
    cyc(0, 0, 0, 0, 0);
    chk("R7 trap held", {15'd0, trapReq}, 16'd1);
    cyc(1, 0, 0, 0, 1);
    chk("R7 new error with ack", {15'd0, trapReq}, 16'd1);
    cyc(0, 0, 0, 0, 1);
    chk("R7 ack clears", {15'd0, trapReq}, 16'd0);
    // R11 write in error cycle does not steer that error
    cyc(1, 0, 1, 16'h0004, 0);
    chk("R11 old enables used", {14'd0, trapReq, haltReq}, 16'h0002);
    cyc(0, 0, 1, 16'h0000, 1);
    // R8 halt priority over trap
    cyc(0, 0, 1, 16'h0006, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R8 halt no trap", {13'd0, trapReq, haltReq, consoleFlag}, 16'h0003);
    cyc(0, 0, 0, 0, 0);
    chk("R8 pulse one cycle", {15'd0, haltReq}, 16'd0);
    chk("R9 console held", {15'd0, consoleFlag}, 16'd1);
    cyc(0, 1, 0, 0, 0);
    chk("R9 init clears console", {15'd0, consoleFlag}, 16'd0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic pe, ini, wr, ack;
      logic [DW-1:0] d;
      pe  = ($urandom % 4) == 0;
      ini = ($urandom % 8) == 0;
      wr  = ($urandom % 3) == 0;
      ack = ($urandom % 4) == 0;
      d   = DW'($urandom);
      cyc(pe, ini, wr, d, ack);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule